// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This controller changes the divider settings of a clock synthesizer without ever exposing the downstream logic to an unstable clock. A single-cycle request carries three divider values: a reference divider (NR), a feedback multiplier (NF) and an output divider (NO). When the controller is idle it accepts the request. In one update it moves the clock mux to the 24 MHz reference bypass and asserts the PLL reset. It then writes the divider fields, stored as value minus one, together with a loop-bandwidth code derived from NF. It keeps the PLL in reset for a fixed settle time and then releases it. After that it samples the lock indication once per microsecond and switches the mux to the PLL output only on a sample where lock is high.

If lock does not arrive within a bounded number of samples, the controller keeps the mux on the bypass, raises a sticky error flag and returns to idle. The flag is cleared by the next request that is accepted. While no reprogramming is in progress, a park input selects a deep-slow 32768 Hz source. The block always reports the effective output frequency in Hz for whichever source the mux currently selects. Microsecond timing is derived from a cycles-per-microsecond parameter.

Top module: `pll_reprog_seq`

## Requirements
- R1: A request seen while busy is low is accepted at that clock edge. At the same edge the mode output becomes slow (code 0), the reset output goes high and busy goes high. The divider outputs keep their old values at that edge.
- R2: One edge after acceptance, the divider outputs take the encoded values NR-1, NF-1 and NO-1.
- R3: The bandwidth output is written at the same edge as the divider outputs, with the value (NF >> 1) - 1.
- R4: The reset output falls exactly SETTLE_US*CYC_PER_US cycles after the edge that loaded the divider outputs.
- R5: Lock is sampled every CYC_PER_US cycles after the reset release. The mode becomes normal (code 1), and busy falls, at the first such sample where lock is high, and at no other time.
- R6: If lock is low on MAX_POLLS consecutive samples, then at the last sample the error output rises, busy falls and the mode stays slow. The error output clears when the next request is accepted.
- R7: A request raised while busy is ignored. It does not restart the sequence, and the divider values of the sequence in progress are the ones that end up loaded.
- R8: The rate output reads 24000000 in slow mode. In normal mode it reads 24000000*NF/(NR*NO), with each value decoded from its field plus one. In deep-slow mode (code 2) or the unused code 3 it reads 32768.
- R9: While idle, a high park input sets the mode to deep-slow (code 2) one edge later. When park drops, the mode returns to the mode left by the last sequence: normal after success, slow after an error or a reset.
- R10: After reset the mode is slow, the reset output and all fields are 0, busy and error are low, and the rate reads 24000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Reprogramming request, one cycle |
| nr_i | input | NR_W | Reference divider value NR |
| nf_i | input | NF_W | Feedback multiplier value NF |
| no_i | input | NO_W | Output divider value NO |
| park_i | input | 1 | Select deep-slow source while idle |
| lock_i | input | 1 | PLL lock status |
| pll_mode_o | output | 2 | Clock mux select: 0 slow, 1 normal, 2 deep-slow |
| pll_rst_o | output | 1 | PLL reset |
| pll_nr_o | output | NR_W | Encoded NR-1 |
| pll_nf_o | output | NF_W | Encoded NF-1 |
| pll_no_o | output | NO_W | Encoded NO-1 |
| pll_bw_o | output | BW_W | Bandwidth code (NF>>1)-1 |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Lock timeout flag |
| rate_hz_o | output | RATE_W | Effective output frequency in Hz |

## Verification
The hardest situation to reach from the ports is the poll boundary. Whether a lock edge is caught on the first, second or third sample depends on the cycle in which the lock rises relative to the one-microsecond grid. That grid starts at the reset release, and the release itself only follows a long settle window. The bench's lock model therefore counts cycles from the observed fall of the reset output and raises lock at chosen offsets: one cycle after release, exactly one interval after release, and one cycle before the third sample. The bench then requires the mode switch on the grid point it predicts for each offset. The timeout case holds lock low for the whole window, and a second request is pulsed during the settle phase to show that it is ignored.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pll_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_POLL   = 2'd3
  } seq_state_e;

  localparam logic [63:0] DEEP_SLOW_HZ = 64'd32768;

  // Bandwidth code for nominal loop bandwidth: half of NF, minus one.
  function automatic logic [31:0] bw_code(input logic [31:0] nf_val);
    return (nf_val >> 1) - 32'd1;
  endfunction

  // Effective output frequency for a mux code and decoded divider values.
  function automatic logic [63:0] rate_of(input logic [1:0]  mode,
                                          input logic [63:0] ref_hz,
                                          input logic [31:0] nr_val,
                                          input logic [31:0] nf_val,
                                          input logic [31:0] no_val);
    logic [63:0] num;
    logic [63:0] den;
    num = ref_hz * 64'(nf_val);
    den = 64'(nr_val) * 64'(no_val);
    case (mode)
      MODE_SLOW:   return ref_hz;
      MODE_NORMAL: return num / den;
      default:     return DEEP_SLOW_HZ;
    endcase
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] value_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_fields.sv
module pll_seq_fields import pll_seq_pkg::*; #(
  parameter int NR_W = 6,
  parameter int NF_W = 13,
  parameter int NO_W = 4,
  parameter int BW_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  output logic [NR_W-1:0] nr_o,
  output logic [NF_W-1:0] nf_o,
  output logic [NO_W-1:0] no_o,
  output logic [BW_W-1:0] bw_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nr_o <= '0;
      nf_o <= '0;
      no_o <= '0;
      bw_o <= '0;
    end else if (we_i) begin
      nr_o <= nr_i - NR_W'(1);
      nf_o <= nf_i - NF_W'(1);
      no_o <= no_i - NO_W'(1);
      bw_o <= BW_W'(bw_code(32'(nf_i)));
    end
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm import pll_seq_pkg::*; #(
  parameter int NR_W       = 6,
  parameter int NF_W       = 13,
  parameter int NO_W       = 4,
  parameter int TW         = 10,
  parameter int SETTLE_CYC = 500,
  parameter int POLL_CYC   = 50,
  parameter int MAX_POLLS  = 16,
  localparam int PW        = $clog2(MAX_POLLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  input  logic            park_i,
  input  logic            lock_i,
  input  logic            tmr_zero_i,
  output logic            tmr_load_o,
  output logic [TW-1:0]   tmr_val_o,
  output logic            fields_we_o,
  output logic [NR_W-1:0] nr_q_o,
  output logic [NF_W-1:0] nf_q_o,
  output logic [NO_W-1:0] no_q_o,
  output logic [1:0]      mode_o,
  output logic            pll_rst_o,
  output logic            busy_o,
  output logic            err_o,
  output logic            rel_evt_o,
  output logic            lock_evt_o,
  output logic            tmo_evt_o
);
  seq_state_e state_q;
  pll_mode_e  mode_q;
  pll_mode_e  rest_q;
  logic [PW-1:0] polls_q;
  logic accept, poll_due, retry;

  assign accept      = (state_q == ST_IDLE) && req_i;
  assign fields_we_o = (state_q == ST_LOAD);
  assign rel_evt_o   = (state_q == ST_SETTLE) && tmr_zero_i;
  assign poll_due    = (state_q == ST_POLL) && tmr_zero_i;
  assign lock_evt_o  = poll_due && lock_i;
  assign tmo_evt_o   = poll_due && !lock_i && (polls_q == PW'(MAX_POLLS - 1));
  assign retry       = poll_due && !lock_i && !tmo_evt_o;
  assign tmr_load_o  = fields_we_o || rel_evt_o || retry;
  assign tmr_val_o   = fields_we_o ? TW'(SETTLE_CYC - 1) : TW'(POLL_CYC - 1);
  assign mode_o      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_SLOW;
      rest_q    <= MODE_SLOW;
      pll_rst_o <= 1'b0;
      busy_o    <= 1'b0;
      err_o     <= 1'b0;
      polls_q   <= '0;
      nr_q_o    <= '0;
      nf_q_o    <= '0;
      no_q_o    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            // Bypass and reset go out in the same update.
            mode_q    <= MODE_SLOW;
            pll_rst_o <= 1'b1;
            busy_o    <= 1'b1;
            err_o     <= 1'b0;
            nr_q_o    <= nr_i;
            nf_q_o    <= nf_i;
            no_q_o    <= no_i;
            state_q   <= ST_LOAD;
          end else begin
            mode_q <= park_i ? MODE_DEEP : rest_q;
          end
        end
        ST_LOAD:   state_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (rel_evt_o) begin
            pll_rst_o <= 1'b0;
            polls_q   <= '0;
            state_q   <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (lock_evt_o) begin
            mode_q  <= MODE_NORMAL;
            rest_q  <= MODE_NORMAL;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (tmo_evt_o) begin
            mode_q  <= MODE_SLOW;
            rest_q  <= MODE_SLOW;
            err_o   <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (retry) begin
            polls_q <= polls_q + PW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: reset is only ever raised together with the bypass
  a_r1_bypass_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst_o) |-> (mode_o == MODE_SLOW) && busy_o);

  // R5: normal mode is entered only on a lock sample that saw lock high
  a_r5_normal_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !err_o) |-> (mode_o == MODE_NORMAL) && $past(lock_i));

  // R6: a timeout leaves the clock on the bypass and ends the sequence
  a_r6_timeout_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (mode_o == MODE_SLOW) && !busy_o);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq import pll_seq_pkg::*; #(
  parameter int          NR_W       = 6,
  parameter int          NF_W       = 13,
  parameter int          NO_W       = 4,
  parameter int          BW_W       = 12,
  parameter int          RATE_W     = 40,
  parameter int          CYC_PER_US = 50,
  parameter int          SETTLE_US  = 10,
  parameter int          MAX_POLLS  = 16,
  parameter logic [63:0] REF_HZ     = 64'd24_000_000,
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US,
  localparam int POLL_CYC   = CYC_PER_US,
  localparam int MAX_CYC    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC,
  localparam int TW         = $clog2(MAX_CYC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [NR_W-1:0]   nr_i,
  input  logic [NF_W-1:0]   nf_i,
  input  logic [NO_W-1:0]   no_i,
  input  logic              park_i,
  input  logic              lock_i,
  output logic [1:0]        pll_mode_o,
  output logic              pll_rst_o,
  output logic [NR_W-1:0]   pll_nr_o,
  output logic [NF_W-1:0]   pll_nf_o,
  output logic [NO_W-1:0]   pll_no_o,
  output logic [BW_W-1:0]   pll_bw_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [RATE_W-1:0] rate_hz_o
);
  logic            tmr_load, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            fields_we, rel_evt, lock_evt, tmo_evt;
  logic [NR_W-1:0] nr_q;
  logic [NF_W-1:0] nf_q;
  logic [NO_W-1:0] no_q;

  pll_seq_fsm #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .TW(TW),
    .SETTLE_CYC(SETTLE_CYC), .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .nr_i(nr_i), .nf_i(nf_i), .no_i(no_i),
    .park_i(park_i), .lock_i(lock_i), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .fields_we_o(fields_we),
    .nr_q_o(nr_q), .nf_q_o(nf_q), .no_q_o(no_q),
    .mode_o(pll_mode_o), .pll_rst_o(pll_rst_o), .busy_o(busy_o), .err_o(err_o),
    .rel_evt_o(rel_evt), .lock_evt_o(lock_evt), .tmo_evt_o(tmo_evt)
  );

  pll_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .value_i(tmr_val), .zero_o(tmr_zero)
  );

  pll_seq_fields #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)) u_fields (
    .clk(clk), .rst_n(rst_n), .we_i(fields_we),
    .nr_i(nr_q), .nf_i(nf_q), .no_i(no_q),
    .nr_o(pll_nr_o), .nf_o(pll_nf_o), .no_o(pll_no_o), .bw_o(pll_bw_o)
  );

  assign rate_hz_o = RATE_W'(rate_of(pll_mode_o, REF_HZ,
                                     32'(pll_nr_o) + 32'd1,
                                     32'(pll_nf_o) + 32'd1,
                                     32'(pll_no_o) + 32'd1));

  // Cycle count since the last field load, used only by the settle check.
  logic [31:0] since_load_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_load_q <= '0;
    else if (fields_we)               since_load_q <= '0;
    else if (since_load_q != '1)      since_load_q <= since_load_q + 32'd1;
  end

  // R1: divider fields are written only while bypassed and in reset
  a_r1_load_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
    fields_we |-> pll_rst_o && (pll_mode_o == MODE_SLOW));

  // R4: reset release comes exactly the settle window after the load
  a_r4_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |-> (since_load_q == 32'(SETTLE_CYC - 1)) && pll_rst_o);

  // R5/R6: lock and timeout decisions are exclusive and happen out of reset
  a_r5_poll_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_evt || tmo_evt) |-> !pll_rst_o && !(lock_evt && tmo_evt));
endmodule

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
  localparam int NR_W = 6, NF_W = 13, NO_W = 4, BW_W = 12, RATE_W = 40;
  localparam int CPU = 50, SUS = 10, MAXP = 8;
  localparam int S = SUS * CPU;
  localparam int P = CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, park = 1'b0, lock = 1'b0;
  logic [NR_W-1:0] nr = '0;
  logic [NF_W-1:0] nf = '0;
  logic [NO_W-1:0] no = '0;
  logic [1:0] mode;
  logic prst, busy, err;
  logic [NR_W-1:0] nr_o;
  logic [NF_W-1:0] nf_o;
  logic [NO_W-1:0] no_o;
  logic [BW_W-1:0] bw_o;
  logic [RATE_W-1:0] rate;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  pll_reprog_seq #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .RATE_W(RATE_W),
                   .CYC_PER_US(CPU), .SETTLE_US(SUS), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .nr_i(nr), .nf_i(nf), .no_i(no),
    .park_i(park), .lock_i(lock), .pll_mode_o(mode), .pll_rst_o(prst),
    .pll_nr_o(nr_o), .pll_nf_o(nf_o), .pll_no_o(no_o), .pll_bw_o(bw_o),
    .busy_o(busy), .err_o(err), .rate_hz_o(rate));

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic longint exp_rate(input int vr, input int vf, input int vo);
    return (64'd24000000 * longint'(vf)) / longint'(vr * vo);
  endfunction

  // Accept a request, check the bypass edge and the field load edge (R1, R2, R3).
  task automatic request(input int vr, input int vf, input int vo);
    int old_nf;
    @(negedge clk);
    old_nf = int'(nf_o);
    lock = 1'b0;
    req = 1'b1; nr = NR_W'(vr); nf = NF_W'(vf); no = NO_W'(vo);
    @(negedge clk);
    req = 1'b0;
    check(mode == 2'd0, "R1", "mode at accept", mode, 0);
    check(prst == 1'b1, "R1", "reset at accept", prst, 1);
    check(busy == 1'b1, "R1", "busy at accept", busy, 1);
    check(int'(nf_o) == old_nf, "R1", "nf field unchanged at accept", nf_o, old_nf);
    check(err == 1'b0, "R6", "error cleared at accept", err, 0);
    check(rate == 40'd24000000, "R8", "slow rate while busy", rate, 24000000);
    @(negedge clk);
    check(int'(nr_o) == vr - 1, "R2", "nr field", nr_o, vr - 1);
    check(int'(nf_o) == vf - 1, "R2", "nf field", nf_o, vf - 1);
    check(int'(no_o) == vo - 1, "R2", "no field", no_o, vo - 1);
    check(int'(bw_o) == (vf >> 1) - 1, "R3", "bandwidth code", bw_o, (vf >> 1) - 1);
  endtask

  // Count cycles until reset drops; optionally pulse an extra request (R4, R7).
  task automatic settle(input bit inject);
    int k = 0;
    while (prst && k < S + 20) begin
      @(negedge clk);
      k++;
      if (inject && k == 5) begin
        req = 1'b1; nr = 6'd5; nf = 13'd100; no = 4'd1;
      end
      if (inject && k == 6) begin
        req = 1'b0;
        check(busy == 1'b1 && prst == 1'b1, "R7", "busy kept after ignored request", busy, 1);
        check(int'(nf_o) != 99, "R7", "fields untouched by ignored request", nf_o, 0);
      end
    end
    check(k == S, "R4", "settle cycles", k, S);
  endtask

  // Raise lock d cycles after release (d <= 0 means never) and check the outcome.
  task automatic poll(input int d, input int vr, input int vf, input int vo);
    int m = 0;
    int exp_m;
    bit early = 0;
    while (busy && m < MAXP * P + 20) begin
      @(negedge clk);
      m++;
      if (d > 0 && m == d) lock = 1'b1;
      if (busy && mode == 2'd1) early = 1;
    end
    check(!early, "R5", "normal mode while busy", early, 0);
    if (d > 0) begin
      exp_m = P * ((d + P) / P);
      check(m == exp_m, "R5", "cycles release to normal", m, exp_m);
      check(mode == 2'd1, "R5", "mode after lock", mode, 1);
      check(err == 1'b0, "R5", "no error after lock", err, 0);
      check(rate == RATE_W'(exp_rate(vr, vf, vo)), "R8", "normal rate", rate, exp_rate(vr, vf, vo));
      check(int'(nf_o) == vf - 1, "R7", "fields of first request kept", nf_o, vf - 1);
    end else begin
      exp_m = MAXP * P;
      check(m == exp_m, "R6", "cycles release to timeout", m, exp_m);
      check(err == 1'b1, "R6", "error flag", err, 1);
      check(mode == 2'd0, "R6", "mode after timeout", mode, 0);
      check(rate == 40'd24000000, "R8", "rate after timeout", rate, 24000000);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(mode == 2'd0, "R10", "reset mode", mode, 0);
    check(prst == 1'b0, "R10", "reset output", prst, 0);
    check(nr_o == '0 && nf_o == '0 && no_o == '0 && bw_o == '0, "R10", "reset fields", nf_o, 0);
    check(!busy && !err, "R10", "reset busy/err", busy, 0);
    check(rate == 40'd24000000, "R10", "reset rate", rate, 24000000);
  endtask

  task automatic t_park(input longint normal_rate);
    @(negedge clk); park = 1'b1;
    @(negedge clk);
    check(mode == 2'd2, "R9", "parked mode", mode, 2);
    check(rate == 40'd32768, "R8", "deep-slow rate", rate, 32768);
    park = 1'b0;
    @(negedge clk);
    check(mode == 2'd1, "R9", "mode after unpark", mode, 1);
    check(rate == RATE_W'(normal_rate), "R8", "rate after unpark", rate, normal_rate);
  endtask

  task automatic t_park_after_error();
    @(negedge clk); park = 1'b1;
    @(negedge clk);
    check(mode == 2'd2, "R9", "parked after error", mode, 2);
    park = 1'b0;
    @(negedge clk);
    check(mode == 2'd0, "R9", "slow after unpark from error", mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // 800 MHz, lock right after release
    request(12, 800, 2); settle(0); poll(1, 12, 800, 2);
    // 816 MHz, lock lands exactly on first sample (caught on second), ignored request
    request(1, 68, 2); settle(1); poll(P, 1, 68, 2);
    // lock never comes
    request(1, 50, 1); settle(0); poll(0, 1, 50, 1);
    t_park_after_error();
    // 1600 MHz after error, lock one cycle before third sample
    request(3, 400, 2); settle(0); poll(3 * P - 1, 3, 400, 2);
    t_park(exp_rate(3, 400, 2));
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule